// File: doc/BRIEF.md
# Framed four-bit pattern detector

This block watches a serial stream of single bits and raises a one-bit flag when a group of four consecutive input bits forms one of two accepted patterns. The stream is cut into fixed, non-overlapping windows of four bits each. After the fourth bit of a window the machine always goes back to its start state, whether or not the window matched. A pattern that straddles two windows is therefore never reported.

Each input bit is qualified by a valid strobe. Only cycles with the strobe high advance the machine. The block has no ready output and never applies back-pressure: every cycle with the strobe high is taken as one bit of the current window. A producer may leave any number of idle cycles between bits, and those cycles neither advance the window nor produce a flag.

The flag is combinational. It comes from the present state, the incoming bit and the strobe, so it is high in the same cycle that carries the window's last bit. The control logic is a reduced seven-state machine held in a three-bit register, with the start state encoded as all zeros.

Top module: `framed_pattern_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the machine returns to the start state. In the first cycle after reset, with `in_valid` low, `match` is 0.
- R2: A window whose bits arrive in the order 0,1,0,1 (first bit leftmost, written 0101) drives `match` to 1 during the cycle that carries its fourth bit.
- R3: A window written 1001 (bits arriving 1,0,0,1) drives `match` to 1 during the cycle that carries its fourth bit.
- R4: `match` is 0 during the first, second and third accepted bits of every window.
- R5: For each of the other fourteen four-bit windows, `match` is 0 on the fourth bit.
- R6: After every fourth accepted bit, the machine returns to the start state unconditionally, so the next accepted bit is the first bit of a new window.
- R7: In a cycle with `in_valid` low, `match` is 0 and the state does not change. A window interrupted by idle cycles is judged as if the idle cycles were absent.
- R8: `match` responds in the same cycle to `in_bit` and `in_valid`, with no register between the inputs and `match`.
- R9: A reset in the middle of a window discards the bits already taken, and the next accepted bit starts a new window.
- R10: The input stream 0101 0010 1001 0100 produces the `match` sequence 0001 0000 0001 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when `in_bit` carries a stream bit this cycle |
| in_bit | input | 1 | Serial data bit |
| match | output | 1 | High in the cycle of the last bit of an accepted window |

## Verification
The bench builds the block with its default parameters: a window length of four and a three-bit state register, so all seven state codes are in use. With these values, all sixteen possible windows can be driven exhaustively. The bench also drives the fixed example stream, windows with idle cycles inside them, a reset part-way through a window, and a change of `in_valid` inside a single cycle that shows the flag follows the inputs combinationally.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int STATE_W   = 3;
  localparam int GROUP_LEN = 4;

  // Reduced machine: the two one-bit states differ, while later states only
  // record whether an accepted pattern is still reachable.
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'b000,
    ST_P0    = 3'b001,
    ST_P1    = 3'b010,
    ST_LIVE2 = 3'b011,
    ST_DEAD2 = 3'b100,
    ST_LIVE3 = 3'b101,
    ST_DEAD3 = 3'b110
  } fpd_state_e;
endpackage

// File: rtl/fpd_next_state.sv
module fpd_next_state
  import fpd_pkg::*;
(
  input  fpd_state_e state,
  input  logic       in_valid,
  input  logic       in_bit,
  output fpd_state_e nxt
);
  always_comb begin
    nxt = state;
    if (in_valid) begin
      unique case (state)
        ST_IDLE:  nxt = in_bit ? ST_P1 : ST_P0;
        ST_P0:    nxt = in_bit ? ST_LIVE2 : ST_DEAD2;
        ST_P1:    nxt = in_bit ? ST_DEAD2 : ST_LIVE2;
        ST_LIVE2: nxt = in_bit ? ST_DEAD3 : ST_LIVE3;
        ST_DEAD2: nxt = ST_DEAD3;
        ST_LIVE3: nxt = ST_IDLE;
        ST_DEAD3: nxt = ST_IDLE;
        default:  nxt = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpd_output.sv
module fpd_output
  import fpd_pkg::*;
(
  input  fpd_state_e state,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       match
);
  // Only the live three-bit state can still complete 0101 or 1001, and in
  // both cases the missing last bit is a one.
  always_comb begin
    match = in_valid && in_bit && (state == ST_LIVE3);
  end
endmodule

// File: rtl/fpd_state_reg.sv
module fpd_state_reg
  import fpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  fpd_state_e nxt,
  output fpd_state_e state
);
  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/framed_pattern_detector.sv
module framed_pattern_detector
  import fpd_pkg::*;
#(
  parameter int WINDOW = GROUP_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic match
);
  localparam int POS_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(WINDOW - 1);

  fpd_state_e state;
  fpd_state_e nxt;

  fpd_next_state u_next (
    .state   (state),
    .in_valid(in_valid),
    .in_bit  (in_bit),
    .nxt     (nxt)
  );

  fpd_state_reg u_reg (
    .clk  (clk),
    .rst  (rst),
    .nxt  (nxt),
    .state(state)
  );

  fpd_output u_out (
    .state   (state),
    .in_valid(in_valid),
    .in_bit  (in_bit),
    .match   (match)
  );

  // Bit position inside the window, kept only for the checks below.
  logic [POS_W-1:0] pos;
  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else if (in_valid) pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
  end

  p_reset_start_r1: assert property (@(posedge clk)
    rst |=> (state == ST_IDLE));

  p_flag_last_bit_r4: assert property (@(posedge clk) disable iff (rst)
    match |-> (pos == LAST_POS));

  p_window_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pos == LAST_POS) |=> (state == ST_IDLE));

  p_legal_code_r6: assert property (@(posedge clk) disable iff (rst)
    state != fpd_state_e'(3'b111));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(state));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> !match);

  p_window_start_r9: assert property (@(posedge clk) disable iff (rst)
    (pos == '0) |-> (state == ST_IDLE));
endmodule

// File: tb/framed_pattern_detector_test.sv
module framed_pattern_detector_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic match;

  int n_checks = 0;
  int n_fail = 0;
  int mpos = 0;
  logic [3:0] mgrp = 4'b0000;

  always #2 clk = ~clk;

  framed_pattern_detector uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit), .match(match)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: match=%b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    mpos = 0; mgrp = 4'b0000;
  endtask

  // Drives one accepted bit and checks match in that same cycle (R8).
  task automatic send_bit(input logic b, input string req);
    logic exp;
    @(negedge clk);
    in_valid = 1'b1; in_bit = b;
    mgrp = {mgrp[2:0], b};
    exp = (mpos == 3) && (mgrp == 4'b0101 || mgrp == 4'b1001);
    #1 check(req, match, exp);
    mpos = (mpos == 3) ? 0 : mpos + 1;
    @(posedge clk);
    #0.5 in_valid = 1'b0;
  endtask

  task automatic send_group(input logic [3:0] g, input string req);
    for (int i = 3; i >= 0; i--) send_bit(g[i], req);
  endtask

  task automatic test_reset();
    do_reset();
    #1 check("R1 after reset", match, 1'b0);
  endtask

  task automatic test_stream();
    logic [15:0] s = 16'b0101_0010_1001_0100;
    logic [15:0] zexp = 16'b0001_0000_0001_0000;
    do_reset();
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      in_valid = 1'b1; in_bit = s[i];
      #1 check("R10 stream", match, zexp[i]);
      @(posedge clk);
      #0.5 in_valid = 1'b0;
    end
  endtask

  task automatic test_all_groups();
    do_reset();
    for (int g = 0; g < 16; g++) begin
      if (g == 5) send_group(4'(g), "R2 window 0101");
      else if (g == 9) send_group(4'(g), "R3 window 1001");
      else send_group(4'(g), "R5/R4 other window");
    end
    send_group(4'b0101, "R6 back-to-back 0101");
    send_group(4'b0101, "R6 back-to-back 0101");
  endtask

  task automatic test_idle_gaps();
    do_reset();
    send_bit(1'b1, "R7 gapped");
    repeat (3) begin
      @(negedge clk); in_valid = 1'b0; in_bit = 1'b1;
      #1 check("R7 idle quiet", match, 1'b0);
    end
    send_bit(1'b0, "R7 gapped");
    send_bit(1'b0, "R7 gapped");
    @(negedge clk); in_valid = 1'b1; in_bit = 1'b1;
    #1 check("R8 same-cycle flag", match, 1'b1);
    in_valid = 1'b0;
    #1 check("R8 flag follows valid", match, 1'b0);
    @(posedge clk);
    send_bit(1'b1, "R7 held across idle edge");
  endtask

  task automatic test_reset_mid();
    do_reset();
    send_bit(1'b1, "R9 prefix");
    send_bit(1'b0, "R9 prefix");
    do_reset();
    send_bit(1'b0, "R9 new window");
    send_bit(1'b1, "R9 new window");
    send_bit(1'b0, "R9 new window");
    send_bit(1'b1, "R9 new window");
  endtask

  initial begin
    #(4 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: done=0 expected 1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    test_reset();
    test_stream();
    test_all_groups();
    test_idle_gaps();
    test_reset_mid();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule